// File: doc/BRIEF.md
# Three-Level DMA Address Sequencer

The sequencer takes one transfer description and walks the source and destination addresses of a transfer built from three nested levels. Bytes form an array, arrays form a frame, and frames form a block. Software writes an eight-word parameter set through a simple indexed write port. Writing the frame-count word arms the sequencer. After that, every sync event releases either one array or one whole frame, depending on the sync mode. Each released array leaves the block as one request carrying the array byte count, the source address, the destination address and the FIFO-mode flags. The data mover that consumes these requests is outside this block.

Control is a three-state machine. `ST_IDLE` means no armed set exists, and all events are dropped. `ST_ARMED` waits for a live or pending event. `ST_ISSUE` emits one request per cycle. The transitions are:
- *arm*: any state goes to `ST_ARMED` on a write to word 7.
- *take*: `ST_ARMED` goes to `ST_ISSUE` on an event.
- *next array*: `ST_ISSUE` stays in `ST_ISSUE` while an AB-synchronised frame still has arrays left.
- *rearm*: `ST_ISSUE` returns to `ST_ARMED` after one array in A-synchronised mode, or at the end of a frame.
- *finish*: `ST_ISSUE` goes to `ST_IDLE` with the final array of the final frame.

The remaining array and frame counts are visible on the ports while the transfer runs.

Top module: `xfer_addr_seq`

## Requirements
- R1: The parameter set has eight 32-bit words selected by `ld_idx`:
  - 0: options
  - 1: source address
  - 2: counts
  - 3: destination address
  - 4: array strides
  - 5: link and reload
  - 6: frame strides
  - 7: frame count

  Writing index 7 arms the sequencer and restarts it. Sync events that arrive before the first arm produce no request.
- R2: Word 2 carries the array byte count in bits 15:0 and the arrays-per-frame count in bits 31:16. Word 7 carries the frame count in bits 15:0. Every request reports the array byte count on `req_bytes`.
- R3: In words 4 and 6, bits 15:0 are the source stride and bits 31:16 are the destination stride. Both are signed 16-bit byte offsets. After each array that is not the last of its frame, each address moves by its array stride.
- R4: The first array of a frame uses the frame's start address plus the frame stride. The address reached by the array steps is not used for this.
- R5: When option bit 2 is 0 (A-synchronised), each taken event produces exactly one request. That request appears in the cycle after the clock edge that samples the event.
- R6: In A-synchronised mode, every frame after the first holds the number of arrays given in word 5 bits 31:16. In AB-synchronised mode, every frame holds the arrays-per-frame count from word 2.
- R7: When option bit 2 is 1 (AB-synchronised), each taken event produces a whole frame of requests on consecutive cycles.
- R8: When option bit 0 is 1, both addresses stay constant for the whole transfer. `req_fifo` is set, and `req_fifo_width` shows option bits 10:8.
- R9: `done` is high exactly in the cycle of the final request of the final frame. Later events produce no request until index 7 is written again.
- R10: One event that arrives while requests are being issued is held in a single pending flag and taken later. Any further events during that time are lost.
- R11: `arr_left` and `frm_left` show, in each request cycle, the arrays remaining in the current frame and the frames remaining, both including the current one. Both read 0 after the block finishes.
- R12: After reset, `req_valid`, `done`, `arr_left` and `frm_left` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Parameter word write strobe |
| ld_idx | input | 3 | Parameter word index |
| ld_data | input | 32 | Parameter word value |
| sync_evt | input | 1 | Sync event, one cycle per event |
| req_valid | output | 1 | Array request valid |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_bytes | output | 16 | Bytes in the array |
| req_fifo | output | 1 | Constant-address FIFO mode active |
| req_fifo_width | output | 3 | FIFO width code |
| done | output | 1 | Final array of the block issued |
| arr_left | output | 16 | Arrays remaining in the current frame |
| frm_left | output | 16 | Frames remaining in the block |

## Verification
The assertions rely on four conditions on the inputs:
- The byte, array, reload and frame counts are all nonzero when the set is armed.
- Words 0 to 6 are written before word 7.
- The option word stays unchanged while a transfer runs.
- `sync_evt` is a plain level that is sampled once per clock.

The stimulus meets these conditions in two ways. It draws every count from a range that starts at one. It always loads a complete set and arms it only while the sequencer is idle or armed, except in the restart case covered by R1.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
    localparam int WORD_W  = 32;
    localparam int NWORDS  = 8;
    localparam int WIDX_W  = $clog2(NWORDS);
    localparam int CNT_W   = 16;
    localparam int FW_W    = 3;
    localparam int FW_LO   = 8;
    localparam int OPT_FIFO_BIT = 0;
    localparam int OPT_AB_BIT   = 2;

    localparam logic [WIDX_W-1:0] W_OPT  = 3'd0;
    localparam logic [WIDX_W-1:0] W_SRC  = 3'd1;
    localparam logic [WIDX_W-1:0] W_CNT  = 3'd2;
    localparam logic [WIDX_W-1:0] W_DST  = 3'd3;
    localparam logic [WIDX_W-1:0] W_ASTR = 3'd4;
    localparam logic [WIDX_W-1:0] W_LINK = 3'd5;
    localparam logic [WIDX_W-1:0] W_FSTR = 3'd6;
    localparam logic [WIDX_W-1:0] W_FRM  = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ISSUE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic              fifo;
        logic              ab;
        logic [FW_W-1:0]   fw;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [CNT_W-1:0]  acnt;
        logic [CNT_W-1:0]  bcnt;
        logic [CNT_W-1:0]  rld;
        logic [CNT_W-1:0]  as_src;
        logic [CNT_W-1:0]  as_dst;
        logic [CNT_W-1:0]  fs_src;
        logic [CNT_W-1:0]  fs_dst;
    } xfer_cfg_t;

    function automatic logic [WORD_W-1:0] sext(input logic [CNT_W-1:0] v);
        return {{(WORD_W-CNT_W){v[CNT_W-1]}}, v};
    endfunction
endpackage

// File: rtl/xseq_param_store.sv
module xseq_param_store
    import xseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output xfer_cfg_t         cfg,
    output logic              arm,
    output logic [CNT_W-1:0]  frm_load
);
    logic [WORD_W-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_idx == WIDX_W'(g))
                q <= wr_data;
        end
        assign words[g] = q;
    end

    assign arm      = wr_en && (wr_idx == W_FRM);
    assign frm_load = wr_data[CNT_W-1:0];

    always_comb begin
        cfg.fifo   = words[W_OPT][OPT_FIFO_BIT];
        cfg.ab     = words[W_OPT][OPT_AB_BIT];
        cfg.fw     = words[W_OPT][FW_LO +: FW_W];
        cfg.src    = words[W_SRC];
        cfg.dst    = words[W_DST];
        cfg.acnt   = words[W_CNT][CNT_W-1:0];
        cfg.bcnt   = words[W_CNT][WORD_W-1:CNT_W];
        cfg.rld    = words[W_LINK][WORD_W-1:CNT_W];
        cfg.as_src = words[W_ASTR][CNT_W-1:0];
        cfg.as_dst = words[W_ASTR][WORD_W-1:CNT_W];
        cfg.fs_src = words[W_FSTR][CNT_W-1:0];
        cfg.fs_dst = words[W_FSTR][WORD_W-1:CNT_W];
    end

    logic unused_bits;
    assign unused_bits = ^{words[W_OPT][WORD_W-1:FW_LO+FW_W], words[W_OPT][FW_LO-1:OPT_AB_BIT+1],
                           words[W_OPT][OPT_AB_BIT-1:OPT_FIFO_BIT+1],
                           words[W_LINK][CNT_W-1:0], words[W_FRM]};
endmodule

// File: rtl/xseq_evt_latch.sv
module xseq_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic take,
    input  logic clr,
    output logic avail
);
    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (clr)
            pend <= 1'b0;
        else if (take)
            pend <= pend & evt;
        else
            pend <= pend | evt;
    end

    assign avail = evt | pend;

    // A pending event is only ever recorded from a real event input
    assert_pend_from_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(evt));
endmodule

// File: rtl/xseq_walker.sv
module xseq_walker
    import xseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [CNT_W-1:0]  frm_load,
    input  xfer_cfg_t         cfg,
    input  logic              evt_avail,
    output logic              take,
    output logic              idle,
    output logic              req_valid,
    output logic [WORD_W-1:0] req_src,
    output logic [WORD_W-1:0] req_dst,
    output logic [CNT_W-1:0]  req_bytes,
    output logic              req_fifo,
    output logic [FW_W-1:0]   req_fw,
    output logic              done,
    output logic [CNT_W-1:0]  arr_left,
    output logic [CNT_W-1:0]  frm_left
);
    seq_state_t state, state_nx;

    logic [WORD_W-1:0] src_cur, dst_cur, src_frm, dst_frm;
    logic [CNT_W-1:0]  arr_cnt, frm_cnt;
    logic [WORD_W-1:0] a_step_s, a_step_d, f_step_s, f_step_d;
    logic [WORD_W-1:0] src_frm_nx, dst_frm_nx;
    logic              frm_last, blk_last;

    assign frm_last = (arr_cnt == CNT_W'(1));
    assign blk_last = frm_last && (frm_cnt == CNT_W'(1));

    assign a_step_s   = cfg.fifo ? '0 : sext(cfg.as_src);
    assign a_step_d   = cfg.fifo ? '0 : sext(cfg.as_dst);
    assign f_step_s   = cfg.fifo ? '0 : sext(cfg.fs_src);
    assign f_step_d   = cfg.fifo ? '0 : sext(cfg.fs_dst);
    assign src_frm_nx = src_frm + f_step_s;
    assign dst_frm_nx = dst_frm + f_step_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (arm) begin
            state_nx = ST_ARMED;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ARMED: if (evt_avail) state_nx = ST_ISSUE;
                ST_ISSUE: begin
                    if (blk_last)
                        state_nx = ST_IDLE;
                    else if (frm_last || !cfg.ab)
                        state_nx = ST_ARMED;
                    else
                        state_nx = ST_ISSUE;
                end
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // address and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_cur <= '0;
            dst_cur <= '0;
            src_frm <= '0;
            dst_frm <= '0;
            arr_cnt <= '0;
            frm_cnt <= '0;
        end else if (arm) begin
            src_cur <= cfg.src;
            dst_cur <= cfg.dst;
            src_frm <= cfg.src;
            dst_frm <= cfg.dst;
            arr_cnt <= cfg.bcnt;
            frm_cnt <= frm_load;
        end else if (state == ST_ISSUE) begin
            if (blk_last) begin
                arr_cnt <= '0;
                frm_cnt <= '0;
            end else if (frm_last) begin
                arr_cnt <= cfg.ab ? cfg.bcnt : cfg.rld;
                frm_cnt <= frm_cnt - CNT_W'(1);
                src_frm <= src_frm_nx;
                dst_frm <= dst_frm_nx;
                src_cur <= src_frm_nx;
                dst_cur <= dst_frm_nx;
            end else begin
                arr_cnt <= arr_cnt - CNT_W'(1);
                src_cur <= src_cur + a_step_s;
                dst_cur <= dst_cur + a_step_d;
            end
        end
    end

    // outputs
    always_comb begin
        req_valid = (state == ST_ISSUE);
        req_src   = src_cur;
        req_dst   = dst_cur;
        req_bytes = cfg.acnt;
        req_fifo  = cfg.fifo;
        req_fw    = cfg.fw;
        done      = (state == ST_ISSUE) && blk_last;
        take      = (state == ST_ARMED) && evt_avail && !arm;
        idle      = (state == ST_IDLE);
        arr_left  = arr_cnt;
        frm_left  = frm_cnt;
    end

    assert_counts_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE) |-> (arr_cnt != '0 && frm_cnt != '0));

    assert_single_array_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg.ab) |=> !req_valid);

    assert_frame_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg.ab && !frm_last && !arm) |=> req_valid);

    assert_fifo_const_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fifo && !arm && state != ST_IDLE) |=> ($stable(src_cur) && $stable(dst_cur)));

    assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !req_valid);
endmodule

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq
    import xseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [WIDX_W-1:0] ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              sync_evt,
    output logic              req_valid,
    output logic [WORD_W-1:0] req_src,
    output logic [WORD_W-1:0] req_dst,
    output logic [CNT_W-1:0]  req_bytes,
    output logic              req_fifo,
    output logic [FW_W-1:0]   req_fifo_width,
    output logic              done,
    output logic [CNT_W-1:0]  arr_left,
    output logic [CNT_W-1:0]  frm_left
);
    xfer_cfg_t        cfg;
    logic             arm, take, idle, evt_avail;
    logic [CNT_W-1:0] frm_load;

    xseq_param_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_en),
        .wr_idx   (ld_idx),
        .wr_data  (ld_data),
        .cfg      (cfg),
        .arm      (arm),
        .frm_load (frm_load)
    );

    xseq_evt_latch u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (sync_evt),
        .take  (take),
        .clr   (arm | idle),
        .avail (evt_avail)
    );

    xseq_walker u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .frm_load  (frm_load),
        .cfg       (cfg),
        .evt_avail (evt_avail),
        .take      (take),
        .idle      (idle),
        .req_valid (req_valid),
        .req_src   (req_src),
        .req_dst   (req_dst),
        .req_bytes (req_bytes),
        .req_fifo  (req_fifo),
        .req_fw    (req_fifo_width),
        .done      (done),
        .arr_left  (arr_left),
        .frm_left  (frm_left)
    );
endmodule

// File: tb/test_xfer_addr_seq.sv
module test_xfer_addr_seq;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic        sync_evt = 1'b0;
    logic        req_valid, req_fifo, done;
    logic [31:0] req_src, req_dst;
    logic [15:0] req_bytes, arr_left, frm_left;
    logic [2:0]  req_fifo_width;

    xfer_addr_seq i_xfer_addr_seq (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .sync_evt(sync_evt), .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst),
        .req_bytes(req_bytes), .req_fifo(req_fifo), .req_fifo_width(req_fifo_width),
        .done(done), .arr_left(arr_left), .frm_left(frm_left)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // reference model of the programmed transfer
    logic [31:0] m_src, m_dst;
    logic [15:0] m_acnt, m_bcnt, m_ccnt, m_rld;
    logic [15:0] m_as_s, m_as_d, m_fs_s, m_fs_d;
    logic        m_fifo, m_ab;
    logic [2:0]  m_fw;
    int          m_c, m_b, win_reqs;
    logic        m_done = 1'b1;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int frame_size(input int c);
        return (c == 0 || m_ab) ? int'(m_bcnt) : int'(m_rld);
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [15:0] as,
                                             input logic [15:0] fs, input int c, input int b);
        if (m_fifo) return base;
        return base + 32'(int'($signed(fs)) * c + int'($signed(as)) * b);
    endfunction

    task automatic observe();
        if (req_valid) begin
            win_reqs++;
            if (m_done) begin
                chk(1'b0, "R9 request while idle", 32'(req_valid), 32'd0);
            end else begin
                automatic int  f = frame_size(m_c);
                automatic logic last = (m_c == int'(m_ccnt) - 1) && (m_b == f - 1);
                chk(req_src == exp_addr(m_src, m_as_s, m_fs_s, m_c, m_b), "R3/R4 src", req_src,
                    exp_addr(m_src, m_as_s, m_fs_s, m_c, m_b));
                chk(req_dst == exp_addr(m_dst, m_as_d, m_fs_d, m_c, m_b), "R3/R4 dst", req_dst,
                    exp_addr(m_dst, m_as_d, m_fs_d, m_c, m_b));
                chk(req_bytes == m_acnt, "R2 bytes", 32'(req_bytes), 32'(m_acnt));
                chk(req_fifo == m_fifo && req_fifo_width == m_fw, "R8 fifo flags",
                    {28'd0, req_fifo, req_fifo_width}, {28'd0, m_fifo, m_fw});
                chk(int'(arr_left) == f - m_b, "R6/R11 arr_left", 32'(arr_left), 32'(f - m_b));
                chk(int'(frm_left) == int'(m_ccnt) - m_c, "R11 frm_left", 32'(frm_left),
                    32'(int'(m_ccnt) - m_c));
                chk(done == last, "R9 done", 32'(done), 32'(last));
                if (m_b == f - 1) begin m_b = 0; m_c++; end
                else m_b++;
                if (last) m_done = 1'b1;
            end
        end else begin
            chk(done == 1'b0, "R9 done without request", 32'(done), 32'd0);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        ld_en = 1'b1; ld_idx = idx; ld_data = d;
        @(negedge clk); observe();
        ld_en = 1'b0;
    endtask

    task automatic load_words();
        wr(3'd0, {21'd0, m_fw, 5'd0, m_ab, 1'b0, m_fifo});
        wr(3'd1, m_src);
        wr(3'd2, {m_bcnt, m_acnt});
        wr(3'd3, m_dst);
        wr(3'd4, {m_as_d, m_as_s});
        wr(3'd5, {m_rld, 16'hFFFF});
        wr(3'd6, {m_fs_d, m_fs_s});
    endtask

    task automatic arm();
        m_c = 0; m_b = 0; m_done = 1'b0;
        wr(3'd7, {16'd0, m_ccnt});
    endtask

    // one event pulse, then watch for nwin cycles; returns requests seen
    task automatic fire(input int nwin, output int got);
        win_reqs = 0;
        sync_evt = 1'b1;
        @(negedge clk); sync_evt = 1'b0; observe();
        for (int i = 1; i < nwin; i++) begin @(negedge clk); observe(); end
        got = win_reqs;
    endtask

    task automatic run_all(input string tag);
        int got;
        if (m_ab) begin
            for (int c = 0; c < int'(m_ccnt); c++) begin
                fire(int'(m_bcnt) + 2, got);
                chk(got == int'(m_bcnt), {tag, " R7 frame per event"}, 32'(got), 32'(m_bcnt));
            end
        end else begin
            for (int c = 0; c < int'(m_ccnt); c++)
                for (int b = 0; b < frame_size(c); b++) begin
                    fire(3, got);
                    chk(got == 1, {tag, " R5 array per event"}, 32'(got), 32'd1);
                end
        end
        chk(m_done, {tag, " R9 block finished"}, 32'(m_done), 32'd1);
        chk(arr_left == 0 && frm_left == 0, {tag, " R11 counts zero"},
            {arr_left, frm_left}, 32'd0);
        fire(4, got);
        chk(got == 0, {tag, " R9 event after done"}, 32'(got), 32'd0);
    endtask

    task automatic set_cfg(input logic ab, input logic fifo, input logic [2:0] fw,
                           input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                           input logic [15:0] r);
        m_ab = ab; m_fifo = fifo; m_fw = fw;
        m_acnt = a; m_bcnt = b; m_ccnt = c; m_rld = r;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int got;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(req_valid == 0 && done == 0, "R12 reset outputs", {30'd0, req_valid, done}, 32'd0);
        chk(arr_left == 0 && frm_left == 0, "R12 reset counts", {arr_left, frm_left}, 32'd0);

        // R1: events before arming are ignored
        m_src = 32'h1000_0000; m_dst = 32'h2000_0000;
        m_as_s = 16'd32; m_as_d = 16'hFFF8; m_fs_s = 16'h0100; m_fs_d = 16'hFE00;
        set_cfg(1'b0, 1'b0, 3'd0, 16'd16, 16'd3, 16'd3, 16'd2);
        load_words();
        fire(4, got);
        chk(got == 0, "R1 no request before arm", 32'(got), 32'd0);

        // A-synchronised with reload
        arm();
        run_all("async");

        // AB-synchronised
        set_cfg(1'b1, 1'b0, 3'd0, 16'd8, 16'd4, 16'd3, 16'd1);
        m_fs_s = 16'hFF00;
        load_words(); arm();
        run_all("absync");

        // FIFO mode
        set_cfg(1'b1, 1'b1, 3'd5, 16'd4, 16'd3, 16'd2, 16'd1);
        load_words(); arm();
        run_all("fifo");

        // single array corner
        set_cfg(1'b0, 1'b0, 3'd0, 16'd1, 16'd1, 16'd1, 16'd1);
        load_words(); arm();
        run_all("single");

        // R10: three back-to-back events, one held, one lost
        set_cfg(1'b1, 1'b0, 3'd0, 16'd2, 16'd4, 16'd3, 16'd1);
        load_words(); arm();
        win_reqs = 0;
        sync_evt = 1'b1;
        for (int i = 0; i < 3; i++) begin @(negedge clk); observe(); end
        sync_evt = 1'b0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); observe(); end
        chk(win_reqs == 8, "R10 pending holds one event", 32'(win_reqs), 32'd8);
        chk(frm_left == 16'd1, "R10 one frame left", 32'(frm_left), 32'd1);
        fire(6, got);
        chk(got == 4 && m_done, "R10 last frame", 32'(got), 32'd4);

        // R1: rearm in the middle of a transfer restarts it
        set_cfg(1'b0, 1'b0, 3'd0, 16'd8, 16'd3, 16'd2, 16'd3);
        load_words(); arm();
        fire(3, got);
        arm();
        run_all("restart R1");

        // constrained random transfers
        for (int t = 0; t < 25; t++) begin
            m_src  = $urandom; m_dst = $urandom;
            m_as_s = 16'($urandom); m_as_d = 16'($urandom);
            m_fs_s = 16'($urandom); m_fs_d = 16'($urandom);
            set_cfg(1'($urandom), 1'(($urandom % 4) == 0), 3'($urandom),
                    16'($urandom_range(1, 64)), 16'($urandom_range(1, 5)),
                    16'($urandom_range(1, 4)), 16'($urandom_range(1, 5)));
            load_words(); arm();
            run_all("random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule